// File: doc/BRIEF.md
# Sponge Rate-Block Padder

This block sits in front of a Keccak-style permutation core. It takes a message one 32-bit word per cycle and packs the words into a 576-bit rate block of 18 words. The first word accepted ends up in the most significant position. When the final word of a message arrives, flagged with a last-word bit and a 2-bit valid-byte count, the block replaces the unused bytes with the SHA3 domain/padding byte 0x06. It then fills the rest of the block with zero words on its own, one per cycle, and sets the top bit of the block's lowest byte (0x80).

A completed block raises `blk_rdy` and `full` together. While `full` is high, no input word is taken. A one-cycle `blk_ack` from the permutation core releases the buffer. A message whose data ends exactly on a block boundary produces one more block that holds only padding. After the padded final block has been produced, the block takes nothing more and produces no further block until the next synchronous reset.

Top module: `sponge_padder`

## Requirements
- R1: A synchronous reset clears `blk` to zero and holds `blk_rdy` and `full` low.
- R2: Each word taken shifts into the least significant 32 bits of `blk` while the older words move up. After 18 words, `blk` holds them with the first word in bits 575:544, and `blk_rdy` and `full` are both high.
- R3: While `full` is high, `din_vld` has no effect. `blk` stays unchanged, and the offered word does not appear in the following block.
- R4: A `blk_ack` pulse while `full` is high makes `blk_rdy` and `full` low in the next cycle, and the buffer takes words again.
- R5: A word taken with `din_last` high keeps its leading `din_nbytes` bytes (byte 0 is bits 31:24). The next byte becomes 0x06 and any later bytes become 0x00. A count of 0 gives 0x06000000.
- R6: `din_nbytes` has no effect on a word taken with `din_last` low; the word is stored unchanged.
- R7: After the last word, the remaining slots of the block fill with zero words, one per cycle, with no input needed. Bit 7 of the block (0x80 in the lowest byte) is set. If the last word itself falls in the final slot, 0x80 is ORed into its padded value, for example 0x06000080 for a count of 0.
- R8: When the message data fills a block exactly, a last word with count 0 offered after the acknowledge yields a block of 0x06 followed by zeros and ending in 0x80.
- R9: After the final padded block is acknowledged, no word is taken and `full` stays low until reset, whatever `din_vld` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Message word, first byte in bits 31:24 |
| din_vld | input | 1 | Word on `din` is offered |
| din_last | input | 1 | Offered word is the last of the message |
| din_nbytes | input | 2 | Valid leading bytes of the last word (0 to 3) |
| blk_ack | input | 1 | Permutation core has taken the block |
| blk | output | 576 | Rate block, first word in the top bits |
| blk_rdy | output | 1 | A complete block is waiting |
| full | output | 1 | Buffer full; input is stalled |

## Verification
A word counter that drifts off by one shows up at the ports quickly. Either `full` rises one cycle early or late, or the 0x80 terminator sits in the wrong word of the block, and both are visible at the first block boundary. A stuck padding or completion state either produces an extra block after the acknowledge, which is seen within 18 idle cycles, or leaves the tail unfilled so that `full` never rises. Such states are caught by the per-message idle window and by the block-by-block comparison against a padded copy of the message built in the bench. Stalled words that leak into the buffer show up as a changed `blk` in the very next cycle.

// File: rtl/sponge_padder.sv
`timescale 1ns/1ps
module sponge_padder #(
  parameter int BLK_WORDS = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [31:0]               din,
  input  logic                      din_vld,
  input  logic                      din_last,
  input  logic [1:0]                din_nbytes,
  input  logic                      blk_ack,
  output logic [BLK_WORDS*32-1:0]   blk,
  output logic                      blk_rdy,
  output logic                      full
);
  localparam int WW = 32;
  localparam int BW = BLK_WORDS * WW;
  localparam int CW = $clog2(BLK_WORDS + 1);
  localparam logic [7:0] PAD_OPEN  = 8'h06;
  localparam logic [7:0] PAD_CLOSE = 8'h80;

  logic [CW-1:0] cnt;
  logic          tail;
  logic          done;
  logic          take, step, last_slot;
  logic [WW-1:0] padded, w;

  assign full      = (cnt == CW'(BLK_WORDS));
  assign blk_rdy   = full;
  assign last_slot = (cnt == CW'(BLK_WORDS - 1));
  assign take      = din_vld && !full && !tail && !done;
  assign step      = take || (tail && !full);

  always_comb begin
    case (din_nbytes)
      2'd0:    padded = {PAD_OPEN, 24'h0};
      2'd1:    padded = {din[31:24], PAD_OPEN, 16'h0};
      2'd2:    padded = {din[31:16], PAD_OPEN, 8'h0};
      default: padded = {din[31:8], PAD_OPEN};
    endcase
  end

  always_comb begin
    if (tail)          w = '0;
    else if (din_last) w = padded;
    else               w = din;
    if (last_slot && (tail || din_last)) w[7:0] = w[7:0] | PAD_CLOSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tail <= 1'b0;
      done <= 1'b0;
      blk  <= '0;
    end else if (full) begin
      if (blk_ack) cnt <= '0;
    end else if (step) begin
      blk <= {blk[BW-WW-1:0], w};
      cnt <= cnt + CW'(1);
      if (take && din_last) begin
        if (last_slot) done <= 1'b1;
        else           tail <= 1'b1;
      end else if (tail && last_slot) begin
        tail <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(BLK_WORDS));

  p_hold_when_full_r3: assert property (@(posedge clk) disable iff (rst)
    full && !blk_ack |=> $stable(blk) && full);

  p_ack_release_r4: assert property (@(posedge clk) disable iff (rst)
    full && blk_ack |=> !full);

  p_tail_marker_r7: assert property (@(posedge clk) disable iff (rst)
    tail && last_slot |=> full && blk[7]);

  p_no_block_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    done && !full |=> !full && $stable(blk));
endmodule

// File: tb/sponge_padder_bench.sv
`timescale 1ns/1ps
module sponge_padder_bench;
  localparam int NW = 18;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] din = '0;
  logic din_vld = 1'b0, din_last = 1'b0, blk_ack = 1'b0;
  logic [1:0] din_nbytes = '0;
  logic [NW*32-1:0] blk;
  logic blk_rdy, full;
  int checks = 0, fails = 0;
  logic [31:0] msg [0:127];
  logic [31:0] expw [0:127];

  sponge_padder #(.BLK_WORDS(NW)) u_sponge_padder (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .din_last(din_last),
    .din_nbytes(din_nbytes), .blk_ack(blk_ack), .blk(blk), .blk_rdy(blk_rdy),
    .full(full));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pad_ref(logic [31:0] d, int n);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      if (b < n)       r[31-8*b -: 8] = d[31-8*b -: 8];
      else if (b == n) r[31-8*b -: 8] = 8'h06;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [575:0] act, logic [575:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din_vld = 1'b0; din_last = 1'b0; blk_ack = 1'b0;
    @(negedge clk);
    chk(blk == '0 && !blk_rdy && !full, "R1 reset state", {blk, blk_rdy, full}, '0);
    rst = 1'b0;
  endtask

  task automatic run_msg(int nfull, int lastn);
    int len, nblk, i, bd;
    logic [575:0] expb, held;
    do_reset();
    for (int k = 0; k < nfull; k++) msg[k] = $urandom;
    msg[nfull] = $urandom;
    for (int k = 0; k < nfull; k++) expw[k] = msg[k];
    expw[nfull] = pad_ref(msg[nfull], lastn);
    len = nfull + 1;
    while (len % NW != 0) begin expw[len] = '0; len++; end
    expw[len-1][7:0] = expw[len-1][7:0] | 8'h80;
    nblk = len / NW;
    i = 0; bd = 0;
    while (bd < nblk) begin
      @(negedge clk);
      if (full) begin
        for (int j = 0; j < NW; j++) expb[575-32*j -: 32] = expw[bd*NW + j];
        chk(blk == expb && blk_rdy, "R2 R5 R6 R7 R8 block content", blk, expb);
        held = blk;
        din_vld = 1'b1; din = $urandom; din_last = $urandom; din_nbytes = $urandom;
        @(negedge clk);
        chk(blk == held && full, "R3 stalled input not taken", blk, held);
        din_vld = 1'b0; blk_ack = 1'b1;
        @(negedge clk);
        blk_ack = 1'b0;
        chk(!full && !blk_rdy, "R4 ack releases buffer", {blk_rdy, full}, '0);
        bd++;
      end else if (i <= nfull) begin
        din_vld = 1'b1; din = msg[i];
        din_last = (i == nfull);
        din_nbytes = (i == nfull) ? 2'(lastn) : 2'($urandom);
        i++;
      end else begin
        din_vld = 1'b0; din_last = 1'b0;
      end
    end
    held = blk;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      din_vld = $urandom; din = $urandom; din_last = $urandom; din_nbytes = $urandom;
    end
    @(negedge clk);
    chk(!full && blk == held, "R9 nothing after final block", blk, held);
    din_vld = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R5 R7: empty message
    run_msg(0, 0);
    // R7: last word in final slot, count 3 gives 0x86 low byte
    run_msg(17, 3);
    // R7: last word count 0 in final slot gives 0x06000080
    run_msg(17, 0);
    // R8: data ends on block boundary, padding-only block follows
    run_msg(18, 0);
    run_msg(36, 2);
    run_msg(5, 1);
    for (int r = 0; r < 8; r++) run_msg($urandom % 60, $urandom % 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule